// File: doc/BRIEF.md
# Four-Entry Instruction Address Translator with Pairwise LRU

This block turns instruction-fetch virtual addresses into physical addresses by means of four fully associative translation entries. Each entry holds a virtual page number, a physical page number, an address-space identifier, a two-bit page-size code, a shared flag and two protection bits. In every cycle where a fetch is presented, the fetch address is compared against all four entries at once. The result is one of four outcomes: a translated address, a multiple-match error, a protection fault, or a request to the larger unified table.

When no entry matches, the block raises a refill request in the same cycle. The unified table answers combinationally on the refill port. If the unified table holds the page, its entry is written into a victim slot at the next clock edge, and the retried fetch hits one cycle later. If the unified table does not hold the page, an instruction miss is reported. The victim slot comes from a six-bit pairwise age field, which is exposed as an output. Within that field, output bit 5 corresponds to control-register bit 31 and output bit 0 to bit 26.

Top module: `itlb4_lru`

## Requirements
- R1: After reset all four entries are invalid and the age field reads 000000, so the first fetch cannot hit.
- R2: An entry matches only if it is valid and the fetch address lies within its page. The page is the entry's page number shifted left 10 bits and aligned to the page size: code 00 is 1 KB, 01 is 4 KB, 10 is 64 KB and 11 is 1 MB. On a hit, the physical address takes its upper bits from the entry's physical page number and its in-page offset from the fetch address.
- R3: The identifier comparison is waived when the entry's shared flag is set. It is also waived when `privMode` and `sharedVm` are both 1, and in no other case; otherwise the entry's identifier must equal `curAsid`.
- R4: If two or more entries match, `multiHit` is raised, and `fetchHit`, `protFault` and `refillReq` stay low.
- R5: When no entry matches, `refillReq` is raised and `fetchHit` is low in that cycle. If `refillHit` is 1, the response fields are written into the victim slot as a valid entry, and the same fetch hits on the following cycle.
- R6: When no entry matches and `refillHit` is 0, `itlbMiss` is raised together with `refillReq`, and no entry is written.
- R7: A single match on a slot, or a refill into a slot, updates the age field as follows:
  - slot 0 clears bits 5, 4 and 3;
  - slot 1 clears bits 2 and 1 and sets bit 5;
  - slot 2 clears bit 0 and sets bits 4 and 2;
  - slot 3 sets bits 3, 1 and 0.
- R8: The victim is chosen by the first of these tests to succeed:
  - slot 0 if bits 5..3 are 111;
  - slot 1 if bit 5 is 0 and bits 2 and 1 are 1;
  - slot 2 if bits 4 and 2 are 0 and bit 0 is 1;
  - slot 3 if bits 3, 1 and 0 are 0.
- R9: A single match with `privMode` 0 on an entry whose protection bit 1 is 0 raises `protFault` instead of `fetchHit`, and the age field is still updated. In privileged mode, the protection bits do not block the fetch.
- R10: When `fetchValid` is 0, all result flags stay low and the age field does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | A fetch address is presented this cycle |
| fetchVa | input | 32 | Fetch virtual address |
| curAsid | input | 8 | Current address-space identifier |
| privMode | input | 1 | 1 = privileged execution |
| sharedVm | input | 1 | Single-virtual-space mode bit; waives identifier checks when privileged |
| refillHit | input | 1 | Unified table holds the requested page |
| refillVpn | input | 22 | Response virtual page number |
| refillPpn | input | 22 | Response physical page number |
| refillAsid | input | 8 | Response identifier |
| refillSize | input | 2 | Response page-size code |
| refillShared | input | 1 | Response shared flag |
| refillPr | input | 2 | Response protection bits |
| refillReq | output | 1 | No entry matched; unified lookup requested |
| physAddr | output | 32 | Translated address, meaningful with `fetchHit` |
| fetchHit | output | 1 | Translation succeeded |
| itlbMiss | output | 1 | Unified table missed too |
| multiHit | output | 1 | More than one entry matched |
| protFault | output | 1 | User fetch from a privileged-only page |
| lruBits | output | 6 | Pairwise age field |

## Verification
Every cycle, the assertions check the following:
- the result flags are mutually exclusive;
- the flags stay quiet without a fetch;
- a miss is tied to a refused refill;
- faults occur only in user mode;
- the age field changes only after a hit, a fault or a completed refill;
- the age field always decodes to some victim.

The exact set and clear masks, the victim sequence and the physical address composition for each page size can only be seen in the bench's scenarios. The same holds for identifier waiving and for the timing of a refill followed by a hit. In those scenarios, a reference model of the entries tracks every fetch.

// File: rtl/itlb4_pkg.sv
package itlb4_pkg;
  localparam int NUM_ENT = 4;
  localparam int LRU_W   = 6;
  localparam int IDX_W   = 2;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrSlot;
  } itlbStrobe_t;

  // number of page-number bits below the page boundary for a size code
  function automatic int sizeShift(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 2;
      2'd2:    return 6;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/itlb4_datapath.sv
module itlb4_datapath
  import itlb4_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PG_SHIFT = 10,
  parameter int ASID_W   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [VA_W-1:0]        fetchVa,
  input  logic [ASID_W-1:0]      curAsid,
  input  logic                   asidChkEn,
  input  itlbStrobe_t            strobe,
  input  logic [VA_W-PG_SHIFT-1:0] refillVpn,
  input  logic [VA_W-PG_SHIFT-1:0] refillPpn,
  input  logic [ASID_W-1:0]      refillAsid,
  input  logic [1:0]             refillSize,
  input  logic                   refillShared,
  input  logic [1:0]             refillPr,
  output logic [NUM_ENT-1:0]     matchVec,
  output logic                   selPrUser,
  output logic [VA_W-1:0]        physAddr
);
  localparam int VPN_W = VA_W - PG_SHIFT;

  logic [NUM_ENT-1:0] entVal;
  logic [VPN_W-1:0]   entVpn  [NUM_ENT];
  logic [VPN_W-1:0]   entPpn  [NUM_ENT];
  logic [ASID_W-1:0]  entAsid [NUM_ENT];
  logic [1:0]         entSz   [NUM_ENT];
  logic               entSh   [NUM_ENT];
  logic [1:0]         entPr   [NUM_ENT];
  logic [VPN_W-1:0]   pgMask  [NUM_ENT];

  wire [VPN_W-1:0] fetchVpn = fetchVa[VA_W-1:PG_SHIFT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) entVal <= '0;
    else if (strobe.wrEn) entVal[strobe.wrSlot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      entVpn[strobe.wrSlot]  <= refillVpn;
      entPpn[strobe.wrSlot]  <= refillPpn;
      entAsid[strobe.wrSlot] <= refillAsid;
      entSz[strobe.wrSlot]   <= refillSize;
      entSh[strobe.wrSlot]   <= refillShared;
      entPr[strobe.wrSlot]   <= refillPr;
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign pgMask[g] = ~((VPN_W'(1) << sizeShift(entSz[g])) - VPN_W'(1));
    assign matchVec[g] = entVal[g]
                      && ((fetchVpn & pgMask[g]) == (entVpn[g] & pgMask[g]))
                      && (!asidChkEn || entSh[g] || (entAsid[g] == curAsid));
  end

  logic [IDX_W-1:0] selIdx;
  always_comb begin
    selIdx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (matchVec[i]) selIdx = IDX_W'(i);
  end

  logic [VA_W-1:0] fullMask;
  always_comb begin
    fullMask  = {pgMask[selIdx], {PG_SHIFT{1'b0}}};
    physAddr  = ({entPpn[selIdx], {PG_SHIFT{1'b0}}} & fullMask) | (fetchVa & ~fullMask);
    selPrUser = entPr[selIdx][1];
  end
endmodule

// File: rtl/itlb4_ctrl.sv
module itlb4_ctrl
  import itlb4_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  input  logic               privMode,
  input  logic [NUM_ENT-1:0] matchVec,
  input  logic               selPrUser,
  input  logic               refillHit,
  output itlbStrobe_t        strobe,
  output logic               refillReq,
  output logic               fetchHit,
  output logic               itlbMiss,
  output logic               multiHit,
  output logic               protFault,
  output logic [LRU_W-1:0]   lruBits
);
  logic [LRU_W-1:0] lruQ;
  logic [IDX_W-1:0] hitIdx, victim;
  logic             noMatch, oneMatch, manyMatch;

  function automatic logic [LRU_W-1:0] touch(input logic [LRU_W-1:0] cur,
                                             input logic [IDX_W-1:0] slot);
    case (slot)
      2'd0:    return cur & 6'b000111;
      2'd1:    return (cur & 6'b111001) | 6'b100000;
      2'd2:    return (cur & 6'b111110) | 6'b010100;
      default: return cur | 6'b001011;
    endcase
  endfunction

  always_comb begin
    hitIdx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (matchVec[i]) hitIdx = IDX_W'(i);
  end

  // fixed-priority victim decode
  always_comb begin
    if (lruQ[5:3] == 3'b111)                   victim = 2'd0;
    else if (!lruQ[5] && lruQ[2] && lruQ[1])   victim = 2'd1;
    else if (!lruQ[4] && !lruQ[2] && lruQ[0])  victim = 2'd2;
    else                                       victim = 2'd3;
  end

  always_comb begin
    manyMatch = |(matchVec & (matchVec - NUM_ENT'(1)));
    noMatch   = (matchVec == '0);
    oneMatch  = !noMatch && !manyMatch;

    multiHit  = fetchValid && manyMatch;
    refillReq = fetchValid && noMatch;
    itlbMiss  = refillReq && !refillHit;
    protFault = fetchValid && oneMatch && !privMode && !selPrUser;
    fetchHit  = fetchValid && oneMatch && !protFault;

    strobe.wrEn   = refillReq && refillHit;
    strobe.wrSlot = victim;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       lruQ <= '0;
    else if (fetchValid && oneMatch) lruQ <= touch(lruQ, hitIdx);
    else if (strobe.wrEn)            lruQ <= touch(lruQ, victim);
  end

  assign lruBits = lruQ;
endmodule

// File: rtl/itlb4_lru.sv
module itlb4_lru
  import itlb4_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PG_SHIFT = 10,
  parameter int ASID_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fetchValid,
  input  logic [VA_W-1:0]          fetchVa,
  input  logic [ASID_W-1:0]        curAsid,
  input  logic                     privMode,
  input  logic                     sharedVm,
  input  logic                     refillHit,
  input  logic [VA_W-PG_SHIFT-1:0] refillVpn,
  input  logic [VA_W-PG_SHIFT-1:0] refillPpn,
  input  logic [ASID_W-1:0]        refillAsid,
  input  logic [1:0]               refillSize,
  input  logic                     refillShared,
  input  logic [1:0]               refillPr,
  output logic                     refillReq,
  output logic [VA_W-1:0]          physAddr,
  output logic                     fetchHit,
  output logic                     itlbMiss,
  output logic                     multiHit,
  output logic                     protFault,
  output logic [LRU_W-1:0]         lruBits
);
  itlbStrobe_t        strobe;
  logic [NUM_ENT-1:0] matchVec;
  logic               selPrUser;
  wire                asidChkEn = !(privMode && sharedVm);

  itlb4_datapath #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .ASID_W(ASID_W)) u_dp (
    .clk(clk), .rstN(rstN), .fetchVa(fetchVa), .curAsid(curAsid),
    .asidChkEn(asidChkEn), .strobe(strobe),
    .refillVpn(refillVpn), .refillPpn(refillPpn), .refillAsid(refillAsid),
    .refillSize(refillSize), .refillShared(refillShared), .refillPr(refillPr),
    .matchVec(matchVec), .selPrUser(selPrUser), .physAddr(physAddr)
  );

  itlb4_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .privMode(privMode),
    .matchVec(matchVec), .selPrUser(selPrUser), .refillHit(refillHit),
    .strobe(strobe), .refillReq(refillReq), .fetchHit(fetchHit),
    .itlbMiss(itlbMiss), .multiHit(multiHit), .protFault(protFault),
    .lruBits(lruBits)
  );
endmodule

// File: rtl/itlb4_lru_chk.sv
module itlb4_lru_chk (
  input logic       clk,
  input logic       rstN,
  input logic       fetchValid,
  input logic       privMode,
  input logic       refillHit,
  input logic       refillReq,
  input logic       fetchHit,
  input logic       itlbMiss,
  input logic       multiHit,
  input logic       protFault,
  input logic [5:0] lruBits
);
  // R4
  exclusive_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fetchHit, multiHit, protFault, refillReq}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> !(fetchHit || itlbMiss || multiHit || protFault || refillReq));

  // R6
  miss_needs_refusal_chk: assert property (@(posedge clk) disable iff (!rstN)
    itlbMiss |-> (refillReq && !refillHit));

  // R9
  fault_user_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> !privMode);

  // R7
  age_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchHit || protFault || (refillReq && refillHit)) |=> $stable(lruBits));

  // R8
  victim_defined_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lruBits[5:3] == 3'b111) || (!lruBits[5] && lruBits[2] && lruBits[1])
    || (!lruBits[4] && !lruBits[2] && lruBits[0])
    || (!lruBits[3] && !lruBits[1] && !lruBits[0]));
endmodule

bind itlb4_lru itlb4_lru_chk u_chk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .privMode(privMode),
  .refillHit(refillHit), .refillReq(refillReq), .fetchHit(fetchHit),
  .itlbMiss(itlbMiss), .multiHit(multiHit), .protFault(protFault),
  .lruBits(lruBits)
);

// File: tb/itlb4_lru_bench.sv
`timescale 1ns/1ps
module itlb4_lru_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchVa = '0;
  logic [7:0]  curAsid = '0;
  logic        privMode = 1'b0, sharedVm = 1'b0;
  logic        refillHit = 1'b0;
  logic [21:0] refillVpn = '0, refillPpn = '0;
  logic [7:0]  refillAsid = '0;
  logic [1:0]  refillSize = '0;
  logic        refillShared = 1'b0;
  logic [1:0]  refillPr = '0;
  logic        refillReq, fetchHit, itlbMiss, multiHit, protFault;
  logic [31:0] physAddr;
  logic [5:0]  lruBits;

  always #2 clk = ~clk;

  itlb4_lru u_itlb4_lru (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference state
  bit          mVal [4];
  logic [21:0] mVpn [4], mPpn [4];
  logic [7:0]  mAsid [4];
  logic [1:0]  mSz [4], mPr [4];
  bit          mSh [4];
  logic [5:0]  mLru;

  function automatic logic [21:0] pageMask(input logic [1:0] sz);
    int k = (sz == 0) ? 0 : (sz == 1) ? 2 : (sz == 2) ? 6 : 10;
    return ~((22'd1 << k) - 22'd1);
  endfunction

  function automatic logic [5:0] ageAfter(input logic [5:0] a, input int s);
    case (s)
      0: return a & ~6'b111000;
      1: return (a & ~6'b000110) | 6'b100000;
      2: return (a & ~6'b000001) | 6'b010100;
      default: return a | 6'b001011;
    endcase
  endfunction

  function automatic int pickVictim(input logic [5:0] a);
    if (a[5] && a[4] && a[3]) return 0;
    if (!a[5] && a[2] && a[1]) return 1;
    if (!a[4] && !a[2] && a[0]) return 2;
    return 3;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit fv, input logic [31:0] va,
                      input logic [7:0] asid, input bit pm, sv, rh,
                      input logic [21:0] ppn, input logic [1:0] sz,
                      input bit sh, input logic [1:0] pr);
    int nm = 0, idx = 0;
    bit eHit, eMiss, eMulti, eProt, eReq;
    logic [31:0] eAddr, fm;
    @(negedge clk);
    fetchValid = fv; fetchVa = va; curAsid = asid; privMode = pm; sharedVm = sv;
    refillHit = rh; refillVpn = va[31:10]; refillPpn = ppn; refillAsid = asid;
    refillSize = sz; refillShared = sh; refillPr = pr;
    #1;
    for (int i = 3; i >= 0; i--) begin
      logic [21:0] m = pageMask(mSz[i]);
      if (mVal[i] && ((va[31:10] & m) == (mVpn[i] & m))
          && (mSh[i] || (pm && sv) || mAsid[i] == asid)) begin
        nm++; idx = i;
      end
    end
    eMulti = fv && nm > 1;
    eReq   = fv && nm == 0;
    eMiss  = eReq && !rh;
    eProt  = fv && nm == 1 && !pm && !mPr[idx][1];
    eHit   = fv && nm == 1 && !eProt;
    fm     = {pageMask(mSz[idx]), 10'h0};
    eAddr  = ({mPpn[idx], 10'h0} & fm) | (va & ~fm);
    check({tag, " flags"}, {fetchHit, itlbMiss, multiHit, protFault, refillReq}
          === {eHit, eMiss, eMulti, eProt, eReq},
          64'({fetchHit, itlbMiss, multiHit, protFault, refillReq}),
          64'({eHit, eMiss, eMulti, eProt, eReq}));
    check("R7/R8 age", lruBits === mLru, 64'(lruBits), 64'(mLru));
    if (eHit) check({tag, " R2 addr"}, physAddr === eAddr, 64'(physAddr), 64'(eAddr));
    if (fv && nm == 1) mLru = ageAfter(mLru, idx);
    else if (eReq && rh) begin
      int v = pickVictim(mLru);
      mVal[v] = 1; mVpn[v] = va[31:10]; mPpn[v] = ppn; mAsid[v] = asid;
      mSz[v] = sz; mSh[v] = sh; mPr[v] = pr;
      mLru = ageAfter(mLru, v);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mVal[i] = 0; mVpn[i] = '0; mPpn[i] = '0; mAsid[i] = '0;
      mSz[i] = '0; mSh[i] = 0; mPr[i] = '0;
    end
    mLru = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset age", lruBits === 6'b0, 64'(lruBits), 64'h0);
    rstN = 1'b1;
    // R10: idle cycle
    step("R10 idle", 0, 32'h0040_0000, 8'h11, 0, 0, 1, 22'h0, 2'd0, 0, 2'b11);
    // R1/R6: first fetch misses, unified miss
    step("R1 R6 first", 1, 32'h0040_0000, 8'h11, 0, 0, 0, 22'h0, 2'd0, 0, 2'b11);
    // R5 R2: refill each page size then sweep offsets inside and beyond
    for (int sz = 0; sz < 4; sz++) begin
      logic [31:0] base = 32'h0040_0000 + 32'(sz) * 32'h0100_0000;
      logic [31:0] pbytes = 32'd1 << (10 + ((sz == 0) ? 0 : (sz == 1) ? 2 : (sz == 2) ? 6 : 10));
      logic [21:0] ppn = 22'h2A5A5 ^ 22'(sz * 22'h01111);
      step("R5 refill", 1, base, 8'h11, 0, 0, 1, ppn, 2'(sz), 0, 2'b11);
      for (int o = 0; o < 6; o++)
        step("R2 offset", 1, base + ((32'(o) * 32'h0001_3579 + 32'(o)) & (pbytes - 1)),
             8'h11, 0, 0, 0, 22'h0, 2'd0, 0, 2'b11);
      step("R2 R6 beyond", 1, base + pbytes, 8'h11, 0, 0, 0, 22'h0, 2'd0, 0, 2'b11);
    end
    // R7 R8: refills beyond capacity exercise victim order
    for (int n = 0; n < 6; n++) begin
      step("R8 evict", 1, 32'h2000_0000 + 32'(n) * 32'h10_0000, 8'h11, 1, 0, 1,
           22'(n + 7), 2'd1, 0, 2'b11);
      step("R7 rehit", 1, 32'h2000_0004 + 32'(n) * 32'h10_0000, 8'h11, 1, 0, 0,
           22'h0, 2'd0, 0, 2'b11);
    end
    // R3: identifier rules
    step("R3 load", 1, 32'h3000_0000, 8'h22, 0, 0, 1, 22'h155, 2'd2, 0, 2'b11);
    step("R3 otherid", 1, 32'h3000_0010, 8'h23, 0, 0, 0, 22'h0, 2'd0, 0, 2'b11);
    step("R3 svuser", 1, 32'h3000_0010, 8'h23, 0, 1, 0, 22'h0, 2'd0, 0, 2'b11);
    step("R3 privnosv", 1, 32'h3000_0010, 8'h23, 1, 0, 0, 22'h0, 2'd0, 0, 2'b11);
    step("R3 bypass", 1, 32'h3000_0010, 8'h23, 1, 1, 0, 22'h0, 2'd0, 0, 2'b11);
    step("R3 shload", 1, 32'h3100_0000, 8'h33, 0, 0, 1, 22'h0AA, 2'd0, 1, 2'b11);
    step("R3 shared", 1, 32'h3100_0200, 8'h44, 0, 0, 0, 22'h0, 2'd0, 0, 2'b11);
    // R4: overlapping pages
    step("R4 big", 1, 32'h0900_0000, 8'h55, 0, 0, 1, 22'h300, 2'd3, 0, 2'b11);
    step("R4 small", 1, 32'h0900_0400, 8'h66, 0, 0, 1, 22'h301, 2'd0, 1, 2'b11);
    step("R4 multi", 1, 32'h0900_0400, 8'h55, 0, 0, 0, 22'h0, 2'd0, 0, 2'b11);
    step("R4 multi2", 1, 32'h0900_07FC, 8'h55, 1, 1, 0, 22'h0, 2'd0, 0, 2'b11);
    // R9: protection
    step("R9 load", 1, 32'h0A00_0000, 8'h77, 1, 0, 1, 22'h123, 2'd1, 0, 2'b00);
    step("R9 priv", 1, 32'h0A00_0100, 8'h77, 1, 0, 0, 22'h0, 2'd0, 0, 2'b00);
    step("R9 user", 1, 32'h0A00_0100, 8'h77, 0, 0, 0, 22'h0, 2'd0, 0, 2'b00);
    step("R9 user2", 1, 32'h0A00_0FFC, 8'h77, 0, 0, 0, 22'h0, 2'd0, 0, 2'b00);
    step("R10 idle2", 0, 32'h0A00_0100, 8'h77, 0, 0, 1, 22'h0, 2'd0, 0, 2'b00);
    step("R10 after", 1, 32'h0A00_0100, 8'h77, 1, 0, 0, 22'h0, 2'd0, 0, 2'b00);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule